// File: doc/BRIEF.md
# Physical Address Cacheability Stage

This stage sits after address translation. It accepts a physical address that came either from a page-table lookup or from a direct kernel superpage window. It produces the address the memory system should use, together with a cacheability decision and at most one fault.

A one-bit platform select chooses between two address layouts:

- **Narrow layout.** 40 physical bits are implemented, and bit 39 marks an uncached access.
- **Wide layout.** 44 physical bits are implemented, and bit 43 marks uncached. Uncached addresses have bits 42:35 cleared. Superpage addresses are sign-extended from bit 40.

An uncached address whose bits 34:32 are all ones lies in internal-register space. The stage does not implement that space and reports it as a fault. Results appear one clock after the request.

Top module: `pa_cache_stage`

## Requirements
- R1: While reset is held, and in the first cycle after it, `out_valid`, `out_paddr`, `out_uncached`, `out_mchk` and `out_unimpl` are all zero.
- R2: A request presented with `in_valid` high at one rising edge produces its result, with `out_valid` high, at the next rising edge.
- R3: On the translated path (`in_superpage`=0), any set bit at or above the implemented width raises `out_mchk`. The width is 40 when `in_mode`=0 and 44 when `in_mode`=1. The address is returned unchanged and no other flag is set.
- R4: With `in_mode`=0, bit 39 is the uncached indicator. An uncached address outside register space sets `out_uncached` and passes unchanged.
- R5: With `in_mode`=1, bit 43 is the uncached indicator and bit 39 has no effect. An uncached address outside register space sets `out_uncached` and returns with bits 42:35 cleared.
- R6: An uncached address whose bits 34:32 are all 1 raises `out_unimpl`. It clears `out_uncached` and is returned unmodified.
- R7: On the superpage path with `in_mode`=1, the address is first limited to 44 bits. If bit 40 is then set, bits 43:40 become 1; otherwise only bits 39:0 are kept. The result then goes through the R5/R6 cacheability decision and never raises `out_mchk`.
- R8: On the superpage path with `in_mode`=0, the address is limited to bits 39:0. It never raises `out_mchk` and is then classified per R4/R6.
- R9: At most one of `out_uncached`, `out_mchk`, `out_unimpl` is high, and all three are low whenever `out_valid` is low.
- R10: An in-range address with the uncached indicator clear passes unchanged, with no flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_paddr | input | 48 | Physical address from translation or superpage mapping |
| in_superpage | input | 1 | 1 when the address came from the superpage window |
| in_mode | input | 1 | Platform layout: 0 narrow (bit 39), 1 wide (bit 43) |
| out_valid | output | 1 | Result present |
| out_paddr | output | 48 | Normalised physical address |
| out_uncached | output | 1 | Access must bypass caches |
| out_mchk | output | 1 | Address exceeds the implemented width |
| out_unimpl | output | 1 | Uncached access to register space |

## Verification
The bench goes after the mode-dependent edges:

- **Bit 40.** It is legal in the wide layout but a machine check in the narrow one. A stage with a fixed mask would accept it, or fault, in both layouts.
- **Bit 39 versus bit 43.** Uncached addresses are tried in each layout. A stage that read the wrong indicator would call a cached address uncached, and the field clear would be exposed if it were applied in the narrow layout or skipped in the wide one.
- **Superpage sign extension.** Addresses with bit 40 set and clear are both used, with junk in the upper bits. This catches a missing extension or a stray machine check on that path.
- **Register-space addresses.** These check that a fault is raised and that the field clear is not applied to them.

// File: rtl/pa_cache_stage.sv
module pa_cache_stage #(
  parameter int PA_W        = 48,
  parameter int WIDE_IMPL   = 44,
  parameter int NARROW_IMPL = 40,
  parameter int UC_WIDE     = 43,
  parameter int UC_NARROW   = 39,
  parameter int SX_BIT      = 40,
  parameter int CLR_HI      = 42,
  parameter int CLR_LO      = 35,
  parameter int REG_LSB     = 32,
  parameter int REG_W       = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [PA_W-1:0] in_paddr,
  input  logic            in_superpage,
  input  logic            in_mode,
  output logic            out_valid,
  output logic [PA_W-1:0] out_paddr,
  output logic            out_uncached,
  output logic            out_mchk,
  output logic            out_unimpl
);
  localparam logic [PA_W-1:0] ONES        = '1;
  localparam logic [PA_W-1:0] WIDE_MASK   = ONES >> (PA_W - WIDE_IMPL);
  localparam logic [PA_W-1:0] NARROW_MASK = ONES >> (PA_W - NARROW_IMPL);
  localparam logic [PA_W-1:0] LOW_MASK    = ONES >> (PA_W - SX_BIT);
  localparam logic [PA_W-1:0] SX_FILL     = WIDE_MASK & ~LOW_MASK;
  localparam logic [PA_W-1:0] CLR_MASK    = (ONES >> (PA_W - CLR_HI - 1)) & ~(ONES >> (PA_W - CLR_LO));

  logic [PA_W-1:0] impl_mask, sp_masked, sp_addr, norm, adj;
  logic            mchk, uc_bit, regsp, unimpl, uc;

  assign impl_mask = in_mode ? WIDE_MASK : NARROW_MASK;
  assign sp_masked = in_paddr & impl_mask;
  assign sp_addr   = (in_mode && sp_masked[SX_BIT]) ? (sp_masked | SX_FILL)
                                                    : (sp_masked & LOW_MASK);
  assign norm      = in_superpage ? sp_addr : in_paddr;

  assign mchk   = |(norm & ~impl_mask);
  assign uc_bit = in_mode ? norm[UC_WIDE] : norm[UC_NARROW];
  assign regsp  = &norm[REG_LSB +: REG_W];
  assign unimpl = !mchk && uc_bit && regsp;
  assign uc     = !mchk && uc_bit && !regsp;
  assign adj    = (uc && in_mode) ? (norm & ~CLR_MASK) : norm;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      out_paddr    <= '0;
      out_uncached <= 1'b0;
      out_mchk     <= 1'b0;
      out_unimpl   <= 1'b0;
    end else begin
      out_valid    <= in_valid;
      out_paddr    <= in_valid ? adj : '0;
      out_uncached <= in_valid && uc;
      out_mchk     <= in_valid && mchk;
      out_unimpl   <= in_valid && unimpl;
    end
  end

  AST_ONE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({out_uncached, out_mchk, out_unimpl})); // R9
  AST_FLAGS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> !(out_uncached || out_mchk || out_unimpl)); // R9
  AST_VALID_LAT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R2
  AST_MCHK_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_superpage && in_mode && |(in_paddr & ~WIDE_MASK)) |=> out_mchk); // R3
  AST_SP_NO_MCHK: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_superpage) |=> !out_mchk); // R7
  AST_WIDE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_mode) |=> (!out_uncached || out_paddr[CLR_HI:CLR_LO] == '0)); // R5
endmodule

// File: tb/pa_cache_stage_tb.sv
module pa_cache_stage_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [47:0] in_paddr = '0;
  logic        in_superpage = 1'b0;
  logic        in_mode = 1'b0;
  logic        out_valid, out_uncached, out_mchk, out_unimpl;
  logic [47:0] out_paddr;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pa_cache_stage u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_paddr(in_paddr),
    .in_superpage(in_superpage), .in_mode(in_mode), .out_valid(out_valid),
    .out_paddr(out_paddr), .out_uncached(out_uncached), .out_mchk(out_mchk),
    .out_unimpl(out_unimpl)
  );

  // {mode, superpage, addr, expected addr, {uc, mchk, unimpl}}
  localparam int N = 13;
  localparam logic [100:0] VEC [N] = '{
    {1'b0, 1'b0, 48'h0012_3456_7800, 48'h0012_3456_7800, 3'b000}, // R10
    {1'b0, 1'b0, 48'h0080_0000_1000, 48'h0080_0000_1000, 3'b100}, // R4
    {1'b0, 1'b0, 48'h0100_0000_0000, 48'h0100_0000_0000, 3'b010}, // R3
    {1'b1, 1'b0, 48'h0100_0000_0000, 48'h0100_0000_0000, 3'b000}, // R3
    {1'b1, 1'b0, 48'h1000_0000_0000, 48'h1000_0000_0000, 3'b010}, // R3
    {1'b1, 1'b0, 48'h08F8_0000_1000, 48'h0800_0000_1000, 3'b100}, // R5
    {1'b1, 1'b0, 48'h0080_0000_1000, 48'h0080_0000_1000, 3'b000}, // R5
    {1'b0, 1'b0, 48'h0087_0000_0040, 48'h0087_0000_0040, 3'b001}, // R6
    {1'b1, 1'b0, 48'h0807_0000_0040, 48'h0807_0000_0040, 3'b001}, // R6
    {1'b1, 1'b1, 48'hABC1_2345_6780, 48'h0801_2345_6780, 3'b100}, // R7
    {1'b1, 1'b1, 48'hFEE5_0000_2000, 48'h00E5_0000_2000, 3'b000}, // R7
    {1'b0, 1'b1, 48'hFFF5_0000_2000, 48'h00F5_0000_2000, 3'b100}, // R8
    {1'b1, 1'b0, 48'h0000_0000_0000, 48'h0000_0000_0000, 3'b000}  // R10
  };

  task automatic chk(input string req, input logic [51:0] act, input logic [51:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 during reset", {out_valid, out_uncached, out_mchk, out_unimpl, out_paddr}, '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset", {out_valid, out_uncached, out_mchk, out_unimpl, out_paddr}, '0);

    for (int i = 0; i < N; i++) begin
      in_valid     = 1'b1;
      in_mode      = VEC[i][100];
      in_superpage = VEC[i][99];
      in_paddr     = VEC[i][98:51];
      @(negedge clk);
      chk($sformatf("vector %0d (R2-R10)", i),
          {out_valid, out_uncached, out_mchk, out_unimpl, out_paddr},
          {1'b1, VEC[i][2:0], VEC[i][50:3]});
    end

    in_valid = 1'b0;
    in_mode  = 1'b0;
    in_paddr = 48'h0100_0000_0000;
    @(negedge clk);
    chk("R9 idle quiet", {out_valid, out_uncached, out_mchk, out_unimpl}, 4'b0000);

    in_valid = 1'b1;
    in_mode  = 1'b1;
    in_superpage = 1'b0;
    in_paddr = 48'h8000_0000_0000;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R3 top bit wide", {out_valid, out_uncached, out_mchk, out_unimpl}, 4'b1010);
    @(negedge clk);
    chk("R2 single cycle", {3'b000, out_valid}, 4'b0000);

    in_valid = 1'b1;
    in_mode  = 1'b0;
    in_superpage = 1'b1;
    in_paddr = 48'hFFFF_FFFF_FFFF;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R8 superpage all ones narrow",
        {out_valid, out_uncached, out_mchk, out_unimpl, out_paddr},
        {4'b1001, 48'h00FF_FFFF_FFFF});

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule